// File: doc/BRIEF.md
# Hysteresis Grid Current Controller

This block produces the four switch commands of a full-bridge inverter that pushes current into the grid in phase with the grid voltage. On every strobed sample it receives three signed Q16.16 values: the measured inverter output current, a current reference that is the scaled grid voltage (no phase-locked loop is involved), and a sample of the boosted DC bus voltage. The measured current is compared against a band of ±1.0 A around the reference. A current below the band turns on the diagonal pair that raises the current. A current above the band turns on the opposite diagonal pair. Inside the band the previous command is kept.

Three conditions force every switch off. The first is an active-low enable held inactive. The second is a bus that has not yet exceeded 54 V since reset. The third is a reference close enough to zero that the bridge should idle around the zero crossing. A final interlock stage refuses any command that would close both switches of one leg. The gate commands are registered, so a sample taken at one clock edge shows on the outputs right after that edge.

Top module: `hyst_grid_ctrl`

## Requirements
- R1: While reset is held, and directly after it, all four gate outputs are 0.
- R2: On a valid sample that is enabled, armed and outside the dead zone, a current strictly below reference minus 1.0 (65536 raw) sets the gates to 4'b1001. In this encoding, bit 0 is leg A high, bit 1 is leg A low, bit 2 is leg B high and bit 3 is leg B low.
- R3: Under the same conditions, a current strictly above reference plus 1.0 sets the gates to 4'b0110.
- R4: Under the same conditions, a current from reference minus 1.0 to reference plus 1.0, both bounds included, leaves the gates unchanged.
- R5: Gates stay 0 until a valid sample carries a bus value strictly above 54.0 (3538944 raw). A bus value equal to 54.0 does not arm the block. The sample that arms the block is already acted on.
- R6: Once armed, the block stays armed until reset, whatever bus values follow.
- R7: A valid sample whose reference lies in [-19660, +19660] raw (±0.3) sets all gates to 0. Both edges of that range are included.
- R8: With the enable input high (inactive), the gates are 0 after the next clock edge, with or without a sample. After the enable input returns low, the gates stay 0 until a sample commands otherwise.
- R9: In a cycle without a valid sample, the gate outputs do not change.
- R10: Bits 0 and 1 are never both 1, and bits 2 and 3 are never both 1.
- R11: The band bounds are computed without wraparound. A reference near the positive or negative limit of the 32-bit range, with a current inside the true band, holds the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low enable; high forces all gates off |
| smp_vld | input | 1 | Marks a cycle that carries a new sample |
| i_meas | input | 32 | Measured output current, signed Q16.16 amperes |
| i_target | input | 32 | Current reference from grid voltage, signed Q16.16 |
| v_bus | input | 32 | Boost bus voltage, signed Q16.16 volts |
| gates | output | 4 | Switch commands: bit0 A-high, bit1 A-low, bit2 B-high, bit3 B-low |

## Verification
The hardest situations to reach from the ports are the wraparound cases of the band bounds. They need references within one ampere of the 32-bit limits, which random stimulus in the normal operating range never produces. Directed samples at 0x7FFF0000 and 0x80000000 cover them, with currents that a wrapped bound would misclassify. The exact band edges, the dead-zone edges and a bus value equal to the trip level are also driven on purpose. These are mixed with seeded random samples in which enable, strobe and bus level vary, and each result is compared with a bench model.

// File: rtl/hgc_pkg.sv
// Shared encodings for the hysteresis grid current controller.
// Assumes a full bridge with two legs and a two-bit command per leg.
package hgc_pkg;

    localparam int LEGS   = 2;
    localparam int GATE_W = 2 * LEGS;

    // Gate bit order: 0 leg A high, 1 leg A low, 2 leg B high, 3 leg B low.
    localparam logic [GATE_W-1:0] GATES_OFF = 4'b0000;
    localparam logic [GATE_W-1:0] GATES_POS = 4'b1001;
    localparam logic [GATE_W-1:0] GATES_NEG = 4'b0110;

    typedef enum logic [1:0] {
        REQ_HOLD = 2'd0,
        REQ_POS  = 2'd1,
        REQ_NEG  = 2'd2
    } hgc_req_e;

endpackage

// File: rtl/hgc_bus_arm.sv
// Bus-voltage arming latch.
// Sets once a strobed bus sample exceeds the trip level and clears only on reset.
// Also offers the combined "armed by now" flag for the sample being processed.
module hgc_bus_arm #(
    parameter int DATA_W = 32,
    parameter int TRIP_Q = 54 * 65536
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] v_bus,
    output logic                     armed,
    output logic                     arm_now
);
    localparam logic signed [DATA_W:0] TRIP_X = (DATA_W+1)'(TRIP_Q);

    logic                   over_trip;
    logic signed [DATA_W:0] bus_x;

    // Purpose: sign-extend the bus sample and compare it strictly against the trip level.
    always_comb begin
        bus_x     = {v_bus[DATA_W-1], v_bus};
        over_trip = bus_x > TRIP_X;
        arm_now   = armed | (smp_vld & over_trip);
    end

    // Purpose: sticky arming register.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= arm_now;
    end

    assert_arm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

endmodule

// File: rtl/hgc_band_cmp.sv
// Band comparator and dead-zone detector.
// Works one bit wider than the data so that reference +/- band cannot wrap.
// Purely combinational; the caller decides when a result is used.
module hgc_band_cmp
    import hgc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BAND_Q = 65536,
    parameter int DZ_Q   = 19660
) (
    input  logic signed [DATA_W-1:0] i_meas,
    input  logic signed [DATA_W-1:0] i_target,
    output hgc_req_e                 req,
    output logic                     in_dz
);
    localparam int EXT_W = DATA_W + 1;
    localparam logic signed [EXT_W-1:0] BAND_X = EXT_W'(BAND_Q);
    localparam logic signed [EXT_W-1:0] DZ_X   = EXT_W'(DZ_Q);

    logic signed [EXT_W-1:0] meas_x, tgt_x, upper_x, lower_x;

    // Purpose: widen the operands and form the hysteresis bounds.
    always_comb begin
        meas_x  = {i_meas[DATA_W-1], i_meas};
        tgt_x   = {i_target[DATA_W-1], i_target};
        upper_x = tgt_x + BAND_X;
        lower_x = tgt_x - BAND_X;
    end

    // Purpose: classify the current against the band and flag the zero-crossing zone.
    always_comb begin
        in_dz = (tgt_x >= -DZ_X) && (tgt_x <= DZ_X);
        if (meas_x < lower_x)      req = REQ_POS;
        else if (meas_x > upper_x) req = REQ_NEG;
        else                       req = REQ_HOLD;
    end

endmodule

// File: rtl/hgc_gate_reg.sv
// Gate command register with forced-off conditions and a per-leg interlock.
// Assumes req/in_dz/arm_now describe the sample present in the same cycle.
module hgc_gate_reg
    import hgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              smp_vld,
    input  logic              arm_now,
    input  logic              in_dz,
    input  hgc_req_e          req,
    output logic [GATE_W-1:0] gates
);
    logic [GATE_W-1:0] want;
    logic [LEGS-1:0]   leg_clash;
    logic              legal;

    // Purpose: choose the next command from enable, strobe, arming, dead zone and band result.
    always_comb begin
        want = gates;
        if (en_n) begin
            want = GATES_OFF;
        end else if (smp_vld) begin
            if (!arm_now || in_dz) begin
                want = GATES_OFF;
            end else begin
                case (req)
                    REQ_POS: want = GATES_POS;
                    REQ_NEG: want = GATES_NEG;
                    default: want = gates;
                endcase
            end
        end
    end

    // Per-leg shoot-through detection on the candidate command.
    for (genvar l = 0; l < LEGS; l++) begin : g_leg
        assign leg_clash[l] = want[2*l] & want[2*l+1];
    end

    assign legal = ~|leg_clash;

    // Purpose: register the command, dropping any that would short a leg.
    always_ff @(posedge clk) begin
        if (!rst_n)     gates <= GATES_OFF;
        else if (legal) gates <= want;
        else            gates <= GATES_OFF;
    end

    assert_leg_a_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[0] && gates[1]));
    assert_leg_b_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[2] && gates[3]));
    assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (gates == GATES_OFF));
    assert_no_sample_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !smp_vld) |=> $stable(gates));
    assert_dead_zone_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && in_dz) |=> (gates == GATES_OFF));

endmodule

// File: rtl/hyst_grid_ctrl.sv
// Hysteresis grid current controller, top level.
// Inputs are signed Q16.16; one sample per asserted smp_vld.
// Gate commands are registered: a sample at edge k shows after edge k.
module hyst_grid_ctrl
    import hgc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 16,
    parameter int BAND_Q = 1 << FRAC_W,
    parameter int DZ_Q   = (3 << FRAC_W) / 10,
    parameter int TRIP_Q = 54 << FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] i_meas,
    input  logic signed [DATA_W-1:0] i_target,
    input  logic signed [DATA_W-1:0] v_bus,
    output logic [GATE_W-1:0]        gates
);
    logic     armed;
    logic     arm_now;
    logic     in_dz;
    hgc_req_e req;

    hgc_bus_arm #(
        .DATA_W (DATA_W),
        .TRIP_Q (TRIP_Q)
    ) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .v_bus   (v_bus),
        .armed   (armed),
        .arm_now (arm_now)
    );

    hgc_band_cmp #(
        .DATA_W (DATA_W),
        .BAND_Q (BAND_Q),
        .DZ_Q   (DZ_Q)
    ) u_cmp (
        .i_meas   (i_meas),
        .i_target (i_target),
        .req      (req),
        .in_dz    (in_dz)
    );

    hgc_gate_reg u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n    (en_n),
        .smp_vld (smp_vld),
        .arm_now (arm_now),
        .in_dz   (in_dz),
        .req     (req),
        .gates   (gates)
    );

    assert_off_until_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (gates == GATES_OFF));

endmodule

// File: tb/hyst_grid_ctrl_test.sv
module hyst_grid_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int ONE    = 65536;
    localparam int DZ     = 19660;
    localparam int TRIP   = 54 * 65536;
    localparam logic [3:0] G_OFF = 4'b0000;
    localparam logic [3:0] G_POS = 4'b1001;
    localparam logic [3:0] G_NEG = 4'b0110;

    logic clk = 1'b0;
    logic rst_n, en_n, smp_vld;
    logic signed [31:0] i_meas, i_target, v_bus;
    logic [3:0] gates;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_gates;
    logic       m_armed;

    always #(CLK_NS/2) clk = ~clk;

    hyst_grid_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .smp_vld(smp_vld),
        .i_meas(i_meas), .i_target(i_target), .v_bus(v_bus), .gates(gates)
    );

    // Bench model of the next gate state from the requirements.
    function automatic logic [3:0] next_gates(input logic [3:0] cur, input logic en,
        input logic v, input int m, input int t, input int b, input logic arm_now);
        longint lm = m, lt = t;
        if (en) return G_OFF;
        if (!v) return cur;
        if (!arm_now) return G_OFF;
        if (lt >= -DZ && lt <= DZ) return G_OFF;
        if (lm < lt - ONE) return G_POS;
        if (lm > lt + ONE) return G_NEG;
        return cur;
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (gates !== exp) begin
            errors++;
            $display("FAIL %s gates actual=%b expected=%b", tag, gates, exp);
        end
    endtask

    // Drives one cycle at a falling edge, checks at the next falling edge.
    task automatic step(input string tag, input logic en, input logic v,
                        input int m, input int t, input int b);
        logic arm_now;
        en_n = en; smp_vld = v; i_meas = m; i_target = t; v_bus = b;
        arm_now = m_armed | (v && (longint'(b) > longint'(TRIP)));
        m_gates = next_gates(m_gates, en, v, m, t, b, arm_now);
        m_armed = arm_now;
        @(negedge clk);
        check(tag, m_gates);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en_n = 1'b0; smp_vld = 1'b1;
        i_meas = -10 * ONE; i_target = 3 * ONE; v_bus = TRIP + ONE;
        repeat (3) @(negedge clk);
        check("R1 in reset", G_OFF);
        rst_n = 1'b1; smp_vld = 1'b0;
        m_gates = G_OFF; m_armed = 1'b0;
        @(negedge clk);
        check("R1 after reset", G_OFF);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; en_n = 1'b0; smp_vld = 1'b0;
        i_meas = 0; i_target = 0; v_bus = 0;
        do_reset();

        // Arming boundary and latch
        step("R5 bus equal trip no arm", 0, 1, -5 * ONE, 2 * ONE, TRIP);
        step("R5 arm and act R2", 0, 1, 0, 2 * ONE, TRIP + 1);
        step("R6 stays armed R3", 0, 1, 5 * ONE, 2 * ONE, 0);
        // Band edges
        step("R4 at upper bound", 0, 1, 3 * ONE, 2 * ONE, 0);
        step("R4 at lower bound", 0, 1, ONE, 2 * ONE, 0);
        step("R2 just below lower", 0, 1, ONE - 1, 2 * ONE, 0);
        step("R9 no sample", 0, 0, 9 * ONE, 2 * ONE, 0);
        step("R3 just above upper", 0, 1, 3 * ONE + 1, 2 * ONE, 0);
        // Dead zone edges
        step("R7 dz positive edge", 0, 1, -5 * ONE, DZ, 0);
        step("R2 outside dz", 0, 1, -5 * ONE, DZ + 1, 0);
        step("R7 dz negative edge", 0, 1, 5 * ONE, -DZ, 0);
        step("R3 outside negative dz", 0, 1, 5 * ONE, -DZ - 1, 0);
        // Enable
        step("R8 disable no sample", 1, 0, 0, 0, 0);
        step("R8 disable with sample", 1, 1, -5 * ONE, 2 * ONE, 0);
        step("R8 re-enable stays off", 0, 0, -5 * ONE, 2 * ONE, 0);
        // Wraparound of the bounds
        step("R11 set pos", 0, 1, 0, 32'sh7FFF0000, 0);
        step("R11 near max hold", 0, 1, 32'sh7FFFFFFF, 32'sh7FFF0000, 0);
        step("R11 set neg", 0, 1, 0, -3 * ONE, 0);
        step("R11 near min hold", 0, 1, 32'sh80000000, 32'sh80000000, 0);

        // Seeded random phase with fresh arming
        do_reset();
        for (int k = 0; k < 600; k++) begin
            int t, m, b;
            logic e, v;
            t = int'($urandom_range(0, 10 * ONE)) - 5 * ONE;
            m = t + int'($urandom_range(0, 4 * ONE)) - 2 * ONE;
            b = ($urandom_range(0, 15) == 0) ? TRIP + int'($urandom_range(0, 3))
                                             : int'($urandom_range(0, TRIP));
            e = ($urandom_range(0, 15) == 0);
            v = ($urandom_range(0, 3) != 0);
            step("R2 R3 R4 R5 R7 R8 R9 random", e, v, m, t, b);
            checks++;
            if ((gates[0] && gates[1]) || (gates[2] && gates[3])) begin
                errors++;
                $display("FAIL R10 leg clash actual=%b expected=no clash", gates);
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule